// File: doc/BRIEF.md
# Half-Word to Word Configuration Write Bridge

This block sits between a 16-bit Wishbone slave port and a 32-bit configuration write path. Software cannot read anything back through it. Each 32-bit configuration register is written as two 16-bit accesses, in order:

- **Low half first.** Writing the half-word at the register's lower address (address bit 1 clear) parks those 16 bits in an internal holding register. Nothing goes downstream.
- **High half second.** Writing the half-word at the upper address (address bit 1 set) joins the two halves and sends them out. The bridge raises a one-clock write strobe with a register index and the 32-bit word `{high, low}`.

The region is 256 bytes and holds 64 registers, four bytes apart. It spans two 128-byte slave slots, and the most significant address bit picks the slot. The Wishbone address is a byte address with bit 0 dropped, so the port carries bits [7:1]. The register index is taken from byte-address bits [7:2]. The slot bit is therefore the top bit of the index, and the index is zero-extended to the output address width.

There is no back-pressure anywhere. The configuration side is a fire-and-forget strobe and must accept every pulse. Wishbone cycles always finish after one wait cycle.

Top module: `cfg_word_bridge`

## Requirements
- R1: After reset, `wb_ack`, `cfg_wr` and the whole of `cfg_addr` and `cfg_data` are zero.
- R2: An access with `wb_cyc` and `wb_stb` high is acknowledged one clock later, and `wb_ack` stays high for only one clock. If the request stays asserted, the bridge acknowledges it on every other clock.
- R3: An acknowledged write with `wb_adr[1]` = 0 stores its data as the low half and does not raise `cfg_wr`.
- R4: An acknowledged write with `wb_adr[1]` = 1 raises `cfg_wr` for exactly one clock, in the same clock as its `wb_ack`. `cfg_data` then equals `{wb_dat_i, held low half}`.
- R5: With the strobe, `cfg_addr` equals byte-address bits [7:2], i.e. `wb_adr[7:2]`, zero-extended. Bit 7 is the slot select.
- R6: Reads are acknowledged with `wb_dat_o` = 0. They raise no strobe and leave the held low half unchanged.
- R7: A high-half write that has no fresh low half before it still strobes, using the most recently held low half. After reset that low half is zero.
- R8: `wb_stb` without `wb_cyc` is ignored. It gives no acknowledge, no strobe, and no change to the held low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wb_cyc | input | 1 | Wishbone bus cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | 7 | Byte address bits [7:1] |
| wb_dat_i | input | 16 | Write data |
| wb_dat_o | output | 16 | Read data, always zero |
| wb_ack | output | 1 | Wishbone acknowledge |
| cfg_wr | output | 1 | One-clock configuration write strobe |
| cfg_addr | output | 8 | Register index, zero-extended |
| cfg_data | output | 32 | Joined 32-bit word |

## Verification
The hardest case to reach is a high half whose low half came from somewhere other than the access just before it. There are three such sources: the reset value, a low half written to a different register, and a low half that survives reads and stray strobes. To reach them, the bench first issues a high-half write straight after reset. It then sweeps all 64 registers in order and follows the sweep with a stb-only low-half attempt and a bare high-half write. Each strobed word is compared against the half-words the bench itself computed.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
endpackage

// File: rtl/cfgb_wb_port.sv
module cfgb_wb_port (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc,
  input  logic stb,
  output logic ack,
  output logic take
);
  // accept one request per ack; held requests get every other clock
  assign take = cyc & stb & ~ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= take;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R2
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(cyc && stb)); // R2
endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode #(
  parameter int ADR_W = 8
) (
  input  logic             take,
  input  logic             we,
  input  logic [ADR_W-1:1] adr,
  output logic             wr_lo,
  output logic             wr_hi,
  output logic [ADR_W-3:0] idx
);
  assign wr_lo = take & we & ~adr[1];
  assign wr_hi = take & we &  adr[1];
  assign idx   = adr[ADR_W-1:2];
endmodule

// File: rtl/cfgb_half_join.sv
module cfgb_half_join #(
  parameter int IDX_W = 6,
  parameter int OUT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_lo,
  input  logic                       wr_hi,
  input  logic [cfgb_pkg::HALF_W-1:0] din,
  input  logic [IDX_W-1:0]           idx,
  output logic                       strobe,
  output logic [OUT_W-1:0]           addr,
  output logic [cfgb_pkg::WORD_W-1:0] data
);
  localparam int PAD_W = OUT_W - IDX_W;

  logic [cfgb_pkg::HALF_W-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else if (wr_lo) low_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe <= 1'b0;
      addr   <= '0;
      data   <= '0;
    end else begin
      strobe <= wr_hi;
      if (wr_hi) begin
        addr <= {{PAD_W{1'b0}}, idx};
        data <= {din, low_q};
      end
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R4
  AST_LO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !strobe); // R3
endmodule

// File: rtl/cfg_word_bridge.sv
module cfg_word_bridge #(
  parameter int ADR_W = 8,
  parameter int OUT_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wb_cyc,
  input  logic                        wb_stb,
  input  logic                        wb_we,
  input  logic [ADR_W-1:1]            wb_adr,
  input  logic [cfgb_pkg::HALF_W-1:0] wb_dat_i,
  output logic [cfgb_pkg::HALF_W-1:0] wb_dat_o,
  output logic                        wb_ack,
  output logic                        cfg_wr,
  output logic [OUT_W-1:0]            cfg_addr,
  output logic [cfgb_pkg::WORD_W-1:0] cfg_data
);
  localparam int IDX_W = ADR_W - 2;

  logic             take, wr_lo, wr_hi;
  logic [IDX_W-1:0] idx;

  assign wb_dat_o = '0;

  cfgb_wb_port u_port (
    .clk(clk), .rst_n(rst_n), .cyc(wb_cyc), .stb(wb_stb),
    .ack(wb_ack), .take(take)
  );

  cfgb_decode #(.ADR_W(ADR_W)) u_dec (
    .take(take), .we(wb_we), .adr(wb_adr),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .idx(idx)
  );

  cfgb_half_join #(.IDX_W(IDX_W), .OUT_W(OUT_W)) u_join (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .din(wb_dat_i), .idx(idx),
    .strobe(cfg_wr), .addr(cfg_addr), .data(cfg_data)
  );

  AST_STROBE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> wb_ack); // R4
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack && !$past(wb_we)) |-> !cfg_wr); // R6
endmodule

// File: tb/cfg_word_bridge_bench.sv
`timescale 1ns/1ps
module cfg_word_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [7:1]  wb_adr = '0;
  logic [15:0] wb_dat_i = '0;
  logic [15:0] wb_dat_o;
  logic        wb_ack, cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_data;

  int total = 0;
  int bad = 0;

  logic        s_ack, s_wr, s_wr_after;
  logic [7:0]  s_addr;
  logic [31:0] s_data;
  logic [15:0] s_rdat;

  always #2 clk = ~clk;

  cfg_word_bridge u_cfg_word_bridge (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_i(wb_dat_i),
    .wb_dat_o(wb_dat_o), .wb_ack(wb_ack), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one access: cyc/stb high for one clock, then observe the clock after
  task automatic access(input logic cyc, input logic we, input logic [5:0] reg_n,
                        input logic half, input logic [15:0] d);
    @(negedge clk);
    wb_cyc = cyc; wb_stb = 1'b1; wb_we = we; wb_adr = {reg_n, half}; wb_dat_i = d;
    @(posedge clk); #1;
    s_ack = wb_ack; s_wr = cfg_wr; s_addr = cfg_addr; s_data = cfg_data; s_rdat = wb_dat_o;
    @(negedge clk);
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    @(posedge clk); #1;
    s_wr_after = cfg_wr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lo, hi, last_lo;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ack", {31'b0, wb_ack}, 32'd0);
    chk("R1 wr", {31'b0, cfg_wr}, 32'd0);
    chk("R1 addr", {24'b0, cfg_addr}, 32'd0);
    chk("R1 data", cfg_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R7: high half straight after reset uses a zero low half
    access(1'b1, 1'b1, 6'd3, 1'b1, 16'hC0DE);
    chk("R7 wr", {31'b0, s_wr}, 32'd1);
    chk("R7 data", s_data, 32'hC0DE_0000);
    chk("R5 addr", {24'b0, s_addr}, 32'd3);

    // sweep every register, lower then upper
    for (int n = 0; n < 64; n++) begin
      lo = 16'(n * 16'h0101) ^ 16'h5A5A;
      hi = 16'(n * 16'h0203 + 16'h1000);
      access(1'b1, 1'b1, 6'(n), 1'b0, lo);
      chk("R2 ack lo", {31'b0, s_ack}, 32'd1);
      chk("R3 no strobe on low half", {31'b0, s_wr}, 32'd0);
      access(1'b1, 1'b1, 6'(n), 1'b1, hi);
      chk("R2 ack hi", {31'b0, s_ack}, 32'd1);
      chk("R4 strobe", {31'b0, s_wr}, 32'd1);
      chk("R4 strobe one clock", {31'b0, s_wr_after}, 32'd0);
      chk("R4 data", s_data, {hi, lo});
      chk("R5 addr", {24'b0, s_addr}, 32'(n));
    end
    last_lo = 16'(63 * 16'h0101) ^ 16'h5A5A;

    // R8: stb without cyc is ignored
    access(1'b0, 1'b1, 6'd7, 1'b0, 16'h1234);
    chk("R8 no ack", {31'b0, s_ack}, 32'd0);
    chk("R8 no strobe", {31'b0, s_wr}, 32'd0);
    access(1'b0, 1'b1, 6'd7, 1'b1, 16'h4321);
    chk("R8 no strobe hi", {31'b0, s_wr}, 32'd0);
    // R7: bare upper half reuses the last held low half
    access(1'b1, 1'b1, 6'd7, 1'b1, 16'hAAAA);
    chk("R7 reuse data", s_data, {16'hAAAA, last_lo});
    chk("R7 reuse addr", {24'b0, s_addr}, 32'd7);

    // R6: reads
    access(1'b1, 1'b1, 6'd5, 1'b0, 16'hBEEF);
    access(1'b1, 1'b0, 6'd5, 1'b0, 16'h0F0F);
    chk("R6 read ack", {31'b0, s_ack}, 32'd1);
    chk("R6 read data", {16'b0, s_rdat}, 32'd0);
    chk("R6 read no strobe", {31'b0, s_wr}, 32'd0);
    access(1'b1, 1'b0, 6'd5, 1'b1, 16'hF0F0);
    chk("R6 read hi no strobe", {31'b0, s_wr}, 32'd0);
    access(1'b1, 1'b1, 6'd5, 1'b1, 16'h1357);
    chk("R6 low half kept", s_data, 32'h1357_BEEF);

    // R2: held request acked every other clock
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = 7'h10;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk("R2 held ack", {31'b0, wb_ack}, (k % 2 == 0) ? 32'd1 : 32'd0);
    end
    @(negedge clk);
    wb_cyc = 1'b0; wb_stb = 1'b0;
    repeat (2) @(posedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule